// File: doc/BRIEF.md
# Packed SIMD Add-Subtract Unit

This block is a 32-bit packed arithmetic datapath. It adds or subtracts two operand words, either as independent lanes or as one whole word. A 4-bit operation code picks the lane class, the direction and a modifier. Depending on the class, the modifier turns on saturation or rounding.

One class is unsigned halfword arithmetic, which can saturate. The other three are halving classes: each averages its lanes and can round half up. They work on unsigned bytes, on signed halfwords and on a signed full word.

The result is purely combinational. A lane that overflows in the unsigned halfword class sets a sticky overflow flag. The flag is registered on the clock edge whenever the valid strobe is high. Only reset or the clear input brings it back to zero.

Top module: `simd_addsub_unit`

## Requirements
- R1: While reset is asserted and after it is released, `ovf_o` is 0 until an overflowing operation is strobed.
- R2: The operation code is split into three fields. `op_i[3:2]` selects the class: 00 is unsigned halfword, 01 is unsigned byte halving, 10 is signed halfword halving and 11 is signed word halving. `op_i[1]`=1 selects subtract (a minus b). `op_i[0]`=1 turns on saturation in class 00 and rounding in the halving classes. Lane 0 always occupies the least significant bits.
- R3: In class 00 add, each 16-bit lane (lane 1 in bits 31:16) is a+b modulo 2^16. A lane sum above 0xFFFF gives 0xFFFF when saturation is on.
- R4: In class 00 subtract, each lane is a-b modulo 2^16. A lane where a<b gives 0x0000 when saturation is on.
- R5: Suppose a class 00 operation overflows in any lane (sum above 0xFFFF, or a<b when subtracting) and `valid_i` is high. Then `ovf_o` is 1 after that rising edge, whichever lane overflowed and whether or not saturation is on.
- R6: In class 01, each of the four byte lanes takes bits 8:1 of the 9-bit unsigned sum or difference. When rounding is on, 1 is added before bit 0 is dropped.
- R7: In class 10, each 16-bit lane is sign-extended to 17 bits and added or subtracted. With rounding on, 1 is added. The 17-bit value is then shifted right arithmetically by one, and the lane keeps 16 bits.
- R8: In class 11, the full words are treated as signed and added or subtracted in 33 bits. With rounding on, 1 is added. The value is then shifted right arithmetically by one, and the result keeps 32 bits.
- R9: The halving classes (01, 10, 11) never set `ovf_o`.
- R10: Once set, `ovf_o` stays 1 until cleared, through any further operation. A cycle with `valid_i` low never changes the flag.
- R11: `clear_i` high clears `ovf_o` at the next rising edge. If a strobed overflowing operation arrives in the same cycle, the flag ends up 1.
- R12: `result_o` depends only on `op_i`, `a_i` and `b_i` in the same cycle, regardless of `valid_i` or the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe: the current operation may update the flag |
| clear_i | input | 1 | Clears the sticky overflow flag at the next edge |
| op_i | input | 4 | Operation code {class[1:0], subtract, modifier} |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Packed combinational result |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Lanes at the extremes are checked in every class.
- **Unsigned halfword class:** 0xFFFF plus 1 and 0 minus 1 are tried with and without the modifier. Overflow is placed in only the high lane or only the low lane. This separates saturation from wrap-around, and checks that each lane raises the flag on its own.
- **Halving classes:** all-ones and 0x8000/0x80000000 operands with odd sums show whether rounding, the ninth or seventeenth carry bit, and the arithmetic sign fill are right.
- **Flag control:** sequences of clear, strobed and unstrobed operations, including clear coinciding with an overflowing strobe, separate sticky hold from the clear priority.
- **Random operands:** random operands across all sixteen codes fill in the remaining combinations.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [1:0] {
    CLS_UHALF     = 2'b00,
    CLS_UBYTE_AVG = 2'b01,
    CLS_SHALF_AVG = 2'b10,
    CLS_WORD_AVG  = 2'b11
  } op_class_e;

  typedef struct packed {
    op_class_e cls;
    logic      sub;
    logic      modf;
  } op_t;

endpackage

// File: rtl/simd_usat_lanes.sv
module simd_usat_lanes #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 2,
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             sat_i,
  output logic [VEC_W-1:0] res_o,
  output logic [LANES-1:0] lane_ovf_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0]   wide;
    logic [LANE_W-1:0] clip;

    always_comb begin
      if (sub_i) begin
        wide = {1'b0, a_i[g*LANE_W +: LANE_W]} - {1'b0, b_i[g*LANE_W +: LANE_W]};
        clip = '0;
      end else begin
        wide = {1'b0, a_i[g*LANE_W +: LANE_W]} + {1'b0, b_i[g*LANE_W +: LANE_W]};
        clip = '1;
      end
    end

    // Carry out on add and borrow out on subtract both land in the top bit.
    assign lane_ovf_o[g] = wide[LANE_W];
    assign res_o[g*LANE_W +: LANE_W] = (wide[LANE_W] && sat_i) ? clip : wide[LANE_W-1:0];
  end

endmodule

// File: rtl/simd_avg_lanes.sv
module simd_avg_lanes #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter bit          SIGNED = 1'b0,
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sub_i,
  input  logic             rnd_i,
  output logic [VEC_W-1:0] res_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la;
    logic [LANE_W-1:0] lb;
    logic [LANE_W:0]   ea;
    logic [LANE_W:0]   eb;
    logic [LANE_W:0]   wide;

    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];
    // One guard bit above the lane: zero fill or sign fill.
    assign ea = {(SIGNED ? la[LANE_W-1] : 1'b0), la};
    assign eb = {(SIGNED ? lb[LANE_W-1] : 1'b0), lb};

    always_comb begin
      if (sub_i) begin
        wide = ea - eb + {{LANE_W{1'b0}}, rnd_i};
      end else begin
        wide = ea + eb + {{LANE_W{1'b0}}, rnd_i};
      end
    end

    // Dropping bit 0 of the guarded value is the one-bit right shift.
    assign res_o[g*LANE_W +: LANE_W] = wide[LANE_W:1];
  end

endmodule

// File: rtl/simd_sticky_flag.sv
module simd_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_as_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned BYTE_W = DATA_W / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clear_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_o
);

  op_t               op;
  logic [DATA_W-1:0] uh_res;
  logic [1:0]        uh_ovf;
  logic [DATA_W-1:0] ub_res;
  logic [DATA_W-1:0] sh_res;
  logic [DATA_W-1:0] sw_res;
  logic              ovf_set;

  assign op = op_t'(op_i);

  simd_usat_lanes #(.LANE_W(HALF_W), .LANES(2)) u_uhalf (
    .a_i(a_i), .b_i(b_i), .sub_i(op.sub), .sat_i(op.modf),
    .res_o(uh_res), .lane_ovf_o(uh_ovf)
  );

  simd_avg_lanes #(.LANE_W(BYTE_W), .LANES(4), .SIGNED(1'b0)) u_ubyte (
    .a_i(a_i), .b_i(b_i), .sub_i(op.sub), .rnd_i(op.modf), .res_o(ub_res)
  );

  simd_avg_lanes #(.LANE_W(HALF_W), .LANES(2), .SIGNED(1'b1)) u_shalf (
    .a_i(a_i), .b_i(b_i), .sub_i(op.sub), .rnd_i(op.modf), .res_o(sh_res)
  );

  simd_avg_lanes #(.LANE_W(DATA_W), .LANES(1), .SIGNED(1'b1)) u_sword (
    .a_i(a_i), .b_i(b_i), .sub_i(op.sub), .rnd_i(op.modf), .res_o(sw_res)
  );

  always_comb begin
    unique case (op.cls)
      CLS_UHALF:     result_o = uh_res;
      CLS_UBYTE_AVG: result_o = ub_res;
      CLS_SHALF_AVG: result_o = sh_res;
      default:       result_o = sw_res;
    endcase
  end

  assign ovf_set = valid_i && (op.cls == CLS_UHALF) && (|uh_ovf);

  simd_sticky_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_set), .clr_i(clear_i), .flag_o(ovf_o)
  );

endmodule

// File: rtl/simd_addsub_unit_chk.sv
module simd_addsub_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        clear_i,
  input logic [3:0]  op_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [31:0] result_o,
  input logic        ovf_o
);

  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clear_i) |=> ovf_o); // R10

  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !valid_i) |=> !ovf_o); // R11

  AST_HALVING_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && (!valid_i || op_i[3:2] != 2'b00)) |=> !ovf_o); // R9

  AST_ADD_LANE0_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[3:1] == 3'b000 &&
     ({1'b0, a_i[15:0]} + {1'b0, b_i[15:0]}) > 17'h0FFFF) |=> ovf_o); // R5

  AST_SAT_ADD_NOT_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'b0001) |-> (result_o[15:0] >= a_i[15:0] && result_o[31:16] >= a_i[31:16])); // R3

  AST_SAT_SUB_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 4'b0011) |-> (result_o[15:0] <= a_i[15:0] && result_o[31:16] <= a_i[31:16])); // R4

endmodule

bind simd_addsub_unit simd_addsub_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .clear_i(clear_i),
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/simd_addsub_unit_tb.sv
`timescale 1ns/1ps
module simd_addsub_unit_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic        clear_i;
  logic [3:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [31:0] result_o;
  logic        ovf_o;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  exp_flag = 1'b0;
  bit  finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  simd_addsub_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .clear_i(clear_i),
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .ovf_o(ovf_o)
  );

  task automatic ref_model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] r, output bit ov);
    bit sub = op[1];
    bit md  = op[0];
    r  = '0;
    ov = 1'b0;
    case (op[3:2])
      2'b00: for (int l = 0; l < 2; l++) begin
        int x = a[16*l +: 16];
        int y = b[16*l +: 16];
        int s = sub ? x - y : x + y;
        if (s > 65535 || s < 0) begin
          ov = 1'b1;
          if (md) s = sub ? 0 : 65535;
        end
        r[16*l +: 16] = s[15:0];
      end
      2'b01: for (int l = 0; l < 4; l++) begin
        int x = a[8*l +: 8];
        int y = b[8*l +: 8];
        int s = sub ? x - y : x + y;
        if (md) s = s + 1;
        s = s >>> 1;
        r[8*l +: 8] = s[7:0];
      end
      2'b10: for (int l = 0; l < 2; l++) begin
        int x = int'($signed(a[16*l +: 16]));
        int y = int'($signed(b[16*l +: 16]));
        int s = sub ? x - y : x + y;
        if (md) s = s + 1;
        s = s >>> 1;
        r[16*l +: 16] = s[15:0];
      end
      default: begin
        longint x = longint'($signed(a));
        longint y = longint'($signed(b));
        longint s = sub ? x - y : x + y;
        if (md) s = s + 1;
        s = s >>> 1;
        r = s[31:0];
      end
    endcase
  endtask

  task automatic check_flag(input string tag);
    n_vec++;
    if (ovf_o !== exp_flag) begin
      n_fail++;
      $display("FAIL %s flag: actual %b expected %b", tag, ovf_o, exp_flag);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input bit vld, input bit clr, input string tag);
    logic [31:0] er;
    bit          eo;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; valid_i = vld; clear_i = clr;
    #1;
    ref_model(op, a, b, er, eo);
    n_vec++;
    if (result_o !== er) begin
      n_fail++;
      $display("FAIL %s result op=%b a=%h b=%h: actual %h expected %h", tag, op, a, b, result_o, er);
    end
    check_flag(tag);
    @(posedge clk_i);
    exp_flag = (clr ? 1'b0 : exp_flag) | (vld & eo);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; clear_i = 1'b0; op_i = '0; a_i = '0; b_i = '0;
    #1;
    check_flag("R1");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_flag("R1");

    // R12: result with strobe low; R10: strobe low never sets
    apply(4'b0000, 32'hFFFF_0001, 32'h0001_0001, 1'b0, 1'b0, "R12");
    apply(4'b0000, 32'h1234_5678, 32'h1111_2222, 1'b1, 1'b0, "R3");
    // R3 wrap / saturate, high lane only overflows
    apply(4'b0000, 32'hFFFF_0010, 32'h0001_0020, 1'b1, 1'b0, "R3");
    apply(4'b0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, "R11");
    apply(4'b0001, 32'h0010_FFFF, 32'h0020_0001, 1'b1, 1'b0, "R5");
    apply(4'b0000, 32'h0, 32'h0, 1'b0, 1'b1, "R11");
    // R4 subtract borrow
    apply(4'b0010, 32'h0005_0000, 32'h0003_0001, 1'b1, 1'b0, "R4");
    apply(4'b0011, 32'h0000_0005, 32'h0001_0003, 1'b1, 1'b0, "R4");
    // R10 sticky through non-overflow and halving ops
    apply(4'b0000, 32'h0001_0001, 32'h0001_0001, 1'b1, 1'b0, "R10");
    apply(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R10");
    // R11 clear with simultaneous overflow: stays set
    apply(4'b0001, 32'h0000_FFFF, 32'h0000_0001, 1'b1, 1'b1, "R11");
    apply(4'b0000, 32'h0, 32'h0, 1'b0, 1'b1, "R11");
    // R6 byte halving
    apply(4'b0100, 32'hFF00_01FF, 32'hFF00_00FF, 1'b1, 1'b0, "R6");
    apply(4'b0101, 32'h0300_0101, 32'h0000_0100, 1'b1, 1'b0, "R6");
    apply(4'b0110, 32'h0000_FF00, 32'h00FF_00FF, 1'b1, 1'b0, "R6");
    apply(4'b0111, 32'h0102_0300, 32'h0201_0001, 1'b1, 1'b0, "R6");
    // R7 signed half halving
    apply(4'b1000, 32'h8000_7FFF, 32'h8000_7FFF, 1'b1, 1'b0, "R7");
    apply(4'b1001, 32'hFFFF_7FFF, 32'h0000_7FFF, 1'b1, 1'b0, "R7");
    apply(4'b1010, 32'h7FFF_8000, 32'h8000_7FFF, 1'b1, 1'b0, "R7");
    apply(4'b1011, 32'h0000_0003, 32'h0001_0000, 1'b1, 1'b0, "R7");
    // R8 word halving
    apply(4'b1100, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0, "R8");
    apply(4'b1101, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, "R8");
    apply(4'b1110, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, "R8");
    apply(4'b1111, 32'h0000_0000, 32'h0000_0002, 1'b1, 1'b0, "R8");
    // R9 halving never sets (flag was cleared above)
    apply(4'b1101, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, "R9");
    // R2 random sweep over all codes
    for (int i = 0; i < 300; i++) begin
      apply(4'(i % 16), $urandom, $urandom, 1'($urandom % 2), 1'($urandom % 5 == 0), "R2");
    end
    @(negedge clk_i);
    #1;
    check_flag("R10");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule